// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block performs one atomic read-modify-write on a single word of a small local storage array on behalf of one requesting lane. A request carries an operation code, a word address, up to two operands, a signed-compare select, a flag that asks for no data to be returned, and a tag. The unit reads the addressed word, computes the new value, and writes it back in consecutive cycles. While it does so it accepts no other request, so operations on any address are serialised.

A returning request ends with a response beat that carries the word as it was before modification. A non-returning request has the same effect on storage but ends with a one-cycle completion pulse and no data. Compare-and-swap operations also advance two statistics counters: one for attempts and one for failed comparisons. An operation code outside the defined set produces an error response and leaves storage and counters untouched.

Top module: `atomic_rmw_unit`

## Requirements
- R1: After reset every storage word reads as zero, both statistics counters are zero, `req_ready` is high, and neither `rsp_valid` nor `done_pulse` is asserted.
- R2: Code 0 stores old AND operand A, code 1 stores old OR A, and code 2 stores old XOR A.
- R3: Code 5 stores old plus A, and code 6 stores old minus A, both modulo 2^WIDTH. Code 7 adds one and code 8 subtracts one, also wrapping, and both ignore the operands.
- R4: Code 4 (exchange) stores operand A unconditionally.
- R5: Code 9 (max) stores A only when A is strictly greater than the old word, and code 10 (min) stores A only when A is strictly less. With `req_signed` high the comparison is two's complement; with it low the comparison is unsigned.
- R6: Code 3 (compare-and-swap) stores operand B only when the old word equals operand A; otherwise the word is left unchanged.
- R7: Each completed compare-and-swap adds one to `cas_attempts`, and each one whose comparison fails also adds one to `cas_failures`. No other operation changes either counter.
- R8: A returning request (`req_noret` low) with a valid code produces `rsp_valid` with `rsp_err` low, `rsp_data` equal to the word before modification, and `rsp_tag` equal to the request tag. The beat is held with stable data until `rsp_ready` is high.
- R9: A non-returning request with a valid code raises `done_pulse` for exactly one cycle with `done_tag` equal to the request tag. It never raises `rsp_valid`, and its effect on storage and counters is the same as the returning form.
- R10: Codes 11 to 15 produce a response with `rsp_err` high, `rsp_data` zero and the request tag, whatever `req_noret` says. Storage and both counters are left unchanged.
- R11: Once a request is accepted, `req_ready` stays low until its response is taken or its completion pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 4 | Operation code (0..10 defined) |
| req_noret | input | 1 | High selects the non-returning form |
| req_signed | input | 1 | Two's-complement compare for max and min |
| req_addr | input | ADDR_W | Word address |
| req_opa | input | WIDTH | Operand A (compare value for compare-and-swap) |
| req_opb | input | WIDTH | Operand B (swap value for compare-and-swap) |
| req_tag | input | TAG_W | Tag returned with the result |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | WIDTH | Word before modification (zero on error) |
| rsp_err | output | 1 | Unrecognised operation code |
| rsp_tag | output | TAG_W | Tag of the answered request |
| done_pulse | output | 1 | One-cycle completion of a non-returning request |
| done_tag | output | TAG_W | Tag of the completed non-returning request |
| cas_attempts | output | CNT_W | Count of compare-and-swap operations |
| cas_failures | output | CNT_W | Count of failed compare-and-swap comparisons |

## Verification
Every defined operation is swept over all ordered pairs from a set of stored and operand values. The set holds zero, one, the largest positive and most negative signed values, all ones and a mixed pattern, so carry and borrow wrap, the sign-sensitive ordering of max and min, and equal against unequal compare-and-swap values all show up in the results. Each sweep is run once with the signed select low and once with it high. Returning and non-returning forms alternate within the sweep, so the same arithmetic is seen through both completion paths. Undefined codes are sent in both forms and then read back, which separates a correct error path from one that writes storage or counts.

// File: rtl/atom_pkg.sv
package atom_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_CAS  = 4'd3,
    OP_EXCH = 4'd4,
    OP_ADD  = 4'd5,
    OP_SUB  = 4'd6,
    OP_INC  = 4'd7,
    OP_DEC  = 4'd8,
    OP_MAX  = 4'd9,
    OP_MIN  = 4'd10
  } atom_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CALC,
    ST_WRITE,
    ST_RESP
  } atom_state_e;

endpackage

// File: rtl/atom_alu.sv
module atom_alu
  import atom_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] nxt,
  output logic             wen,
  output logic             bad_op,
  output logic             cas_miss
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // strict ordering test, sign-aware on request
  function automatic logic above(input logic [WIDTH-1:0] x,
                                 input logic [WIDTH-1:0] y,
                                 input logic             sg);
    if (sg) return $signed(x) > $signed(y);
    return x > y;
  endfunction

  function automatic logic [WIDTH-1:0] wrap_add(input logic [WIDTH-1:0] x,
                                                input logic [WIDTH-1:0] y);
    return x + y;
  endfunction

  function automatic logic [WIDTH-1:0] wrap_sub(input logic [WIDTH-1:0] x,
                                                input logic [WIDTH-1:0] y);
    return x - y;
  endfunction

  always_comb begin
    nxt      = cur;
    wen      = 1'b1;
    bad_op   = 1'b0;
    cas_miss = 1'b0;
    case (op)
      OP_AND:  nxt = cur & opa;
      OP_OR:   nxt = cur | opa;
      OP_XOR:  nxt = cur ^ opa;
      OP_CAS: begin
        if (cur == opa) nxt = opb;
        else begin
          wen      = 1'b0;
          cas_miss = 1'b1;
        end
      end
      OP_EXCH: nxt = opa;
      OP_ADD:  nxt = wrap_add(cur, opa);
      OP_SUB:  nxt = wrap_sub(cur, opa);
      OP_INC:  nxt = wrap_add(cur, ONE);
      OP_DEC:  nxt = wrap_sub(cur, ONE);
      OP_MAX: begin
        if (above(opa, cur, is_signed)) nxt = opa;
        else wen = 1'b0;
      end
      OP_MIN: begin
        if (above(cur, opa, is_signed)) nxt = opa;
        else wen = 1'b0;
      end
      default: begin
        wen    = 1'b0;
        bad_op = 1'b1;
      end
    endcase
  end

  // R10
  always_comb begin
    if (bad_op) begin
      bad_op_nowrite_chk: assert (!wen && !cas_miss);
    end
  end

endmodule

// File: rtl/atom_store.sv
module atom_store #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WIDTH-1:0]  rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data
);

  logic [WIDTH-1:0] words [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                                    words[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g))       words[g] <= wr_data;
    end
  end

  assign rd_data = words[rd_addr];

endmodule

// File: rtl/atom_stats.sv
module atom_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cas_evt,
  input  logic             cas_miss,
  output logic [CNT_W-1:0] attempts,
  output logic [CNT_W-1:0] failures
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      attempts <= '0;
      failures <= '0;
    end else if (cas_evt) begin
      attempts <= attempts + CNT_W'(1);
      if (cas_miss) failures <= failures + CNT_W'(1);
    end
  end

  // R7
  fail_follows_attempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (failures != $past(failures)) |-> (attempts != $past(attempts)));

endmodule

// File: rtl/atomic_rmw_unit.sv
module atomic_rmw_unit
  import atom_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16,
  parameter int TAG_W = 4,
  parameter int CNT_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [3:0]        req_op,
  input  logic              req_noret,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WIDTH-1:0]  req_opa,
  input  logic [WIDTH-1:0]  req_opb,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WIDTH-1:0]  rsp_data,
  output logic              rsp_err,
  output logic [TAG_W-1:0]  rsp_tag,
  output logic              done_pulse,
  output logic [TAG_W-1:0]  done_tag,
  output logic [CNT_W-1:0]  cas_attempts,
  output logic [CNT_W-1:0]  cas_failures
);

  atom_state_e       state;
  logic [3:0]        op_q;
  logic              noret_q, sgn_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WIDTH-1:0]  a_q, b_q, old_q, new_q;
  logic [TAG_W-1:0]  tag_q;
  logic              wen_q, err_q, miss_q, done_q;

  // named internal events
  logic             accept;
  logic             wr_fire;
  logic             cas_evt;
  logic             rsp_take;
  logic [WIDTH-1:0] rd_word;
  logic [WIDTH-1:0] alu_nxt;
  logic             alu_wen, alu_bad, alu_miss;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rsp_take  = rsp_valid && rsp_ready;
  assign wr_fire   = (state == ST_WRITE) && wen_q && !err_q;
  assign cas_evt   = (state == ST_WRITE) && !err_q && (op_q == OP_CAS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= '0;
      noret_q <= 1'b0;
      sgn_q   <= 1'b0;
      addr_q  <= '0;
      a_q     <= '0;
      b_q     <= '0;
      tag_q   <= '0;
      old_q   <= '0;
      new_q   <= '0;
      wen_q   <= 1'b0;
      err_q   <= 1'b0;
      miss_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= req_op;
            noret_q <= req_noret;
            sgn_q   <= req_signed;
            addr_q  <= req_addr;
            a_q     <= req_opa;
            b_q     <= req_opb;
            tag_q   <= req_tag;
            state   <= ST_READ;
          end
        end
        ST_READ: begin
          old_q <= rd_word;
          state <= ST_CALC;
        end
        ST_CALC: begin
          new_q  <= alu_nxt;
          wen_q  <= alu_wen;
          err_q  <= alu_bad;
          miss_q <= alu_miss;
          state  <= ST_WRITE;
        end
        ST_WRITE: begin
          if (err_q || !noret_q) state <= ST_RESP;
          else begin
            done_q <= 1'b1;
            state  <= ST_IDLE;
          end
        end
        ST_RESP: begin
          if (rsp_take) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  atom_store #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH)
  ) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (addr_q),
    .rd_data (rd_word),
    .wr_en   (wr_fire),
    .wr_addr (addr_q),
    .wr_data (new_q)
  );

  atom_alu #(
    .WIDTH (WIDTH)
  ) i_alu (
    .op        (op_q),
    .is_signed (sgn_q),
    .cur       (old_q),
    .opa       (a_q),
    .opb       (b_q),
    .nxt       (alu_nxt),
    .wen       (alu_wen),
    .bad_op    (alu_bad),
    .cas_miss  (alu_miss)
  );

  atom_stats #(
    .CNT_W (CNT_W)
  ) i_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .cas_evt  (cas_evt),
    .cas_miss (miss_q),
    .attempts (cas_attempts),
    .failures (cas_failures)
  );

  assign rsp_valid  = (state == ST_RESP);
  assign rsp_err    = rsp_valid && err_q;
  assign rsp_data   = (rsp_valid && !err_q) ? old_q : '0;
  assign rsp_tag    = tag_q;
  assign done_pulse = done_q;
  assign done_tag   = tag_q;

  // R11
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_tag)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R9
  done_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> !rsp_valid);

  // R10
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_data == '0));

  // R10
  err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WRITE) && err_q) |-> (!wen_q && !cas_evt));

endmodule

// File: tb/test_atomic_rmw_unit.sv
module test_atomic_rmw_unit;

  localparam int W  = 32;
  localparam int D  = 16;
  localparam int AW = 4;
  localparam int TW = 4;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [3:0]    req_op = '0;
  logic          req_noret = 1'b0;
  logic          req_signed = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [W-1:0]  req_opa = '0;
  logic [W-1:0]  req_opb = '0;
  logic [TW-1:0] req_tag = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b0;
  logic [W-1:0]  rsp_data;
  logic          rsp_err;
  logic [TW-1:0] rsp_tag;
  logic          done_pulse;
  logic [TW-1:0] done_tag;
  logic [CW-1:0] cas_attempts, cas_failures;

  always #5 clk = ~clk;

  atomic_rmw_unit #(.WIDTH(W), .DEPTH(D), .TAG_W(TW), .CNT_W(CW)) i_atomic_rmw_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_noret(req_noret), .req_signed(req_signed),
    .req_addr(req_addr), .req_opa(req_opa), .req_opb(req_opb), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_err(rsp_err), .rsp_tag(rsp_tag), .done_pulse(done_pulse),
    .done_tag(done_tag), .cas_attempts(cas_attempts), .cas_failures(cas_failures)
  );

  int n_run = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [W-1:0] shadow [D];
  int exp_att = 0;
  int exp_fail = 0;
  logic [3:0] tag_ctr = '0;

  logic [W-1:0] vals [6];
  initial begin
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7fff_ffff;
    vals[3] = 32'h8000_0000; vals[4] = 32'hffff_ffff; vals[5] = 32'h5a5a_1234;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent reference: sign handled by flipping the top bit
  function automatic logic [W-1:0] ref_next(input int op, input bit sg, input logic [W-1:0] m,
                                            input logic [W-1:0] a, input logic [W-1:0] b,
                                            output bit fail_cas);
    logic [W-1:0] km, ka, r;
    longint unsigned s;
    km = sg ? (m ^ 32'h8000_0000) : m;
    ka = sg ? (a ^ 32'h8000_0000) : a;
    fail_cas = 1'b0;
    r = m;
    if (op == 0) r = ~(~m | ~a);
    else if (op == 1) r = ~(~m & ~a);
    else if (op == 2) r = (m & ~a) | (~m & a);
    else if (op == 3) begin if (m === a) r = b; else fail_cas = 1'b1; end
    else if (op == 4) r = a;
    else if (op == 5) begin s = longint'(m) + longint'(a); r = s[31:0]; end
    else if (op == 6) begin s = 64'h1_0000_0000 + longint'(m) - longint'(a); r = s[31:0]; end
    else if (op == 7) begin s = longint'(m) + 1; r = s[31:0]; end
    else if (op == 8) begin s = 64'h1_0000_0000 + longint'(m) - 1; r = s[31:0]; end
    else if (op == 9) begin if (ka > km) r = a; end
    else if (op == 10) begin if (ka < km) r = a; end
    return r;
  endfunction

  task automatic run_op(input logic [3:0] op, input bit nr, input bit sg, input logic [AW-1:0] ad,
                        input logic [W-1:0] a, input logic [W-1:0] b, input int hold,
                        output logic [W-1:0] data, output bit err, output bit got_rsp,
                        output bit got_done, output logic [TW-1:0] otag, output logic [TW-1:0] itag);
    int n;
    bit leak;
    logic [W-1:0] d0;
    while (!req_ready) @(negedge clk);
    tag_ctr = tag_ctr + 4'd1;
    itag = tag_ctr;
    req_op = op; req_noret = nr; req_signed = sg; req_addr = ad;
    req_opa = a; req_opb = b; req_tag = itag; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0; leak = 1'b0; got_rsp = 1'b0; got_done = 1'b0; data = '0; err = 1'b0; otag = '0;
    while (!rsp_valid && !done_pulse && n < 50) begin
      if (req_ready) leak = 1'b1;
      @(negedge clk);
      n++;
    end
    // R11
    chk(!leak, "R11 ready low while busy", {63'd0, leak}, 64'd0);
    chk(n < 50, "R11 operation completes", n, 0);
    if (rsp_valid) begin
      got_rsp = 1'b1; data = rsp_data; err = rsp_err; otag = rsp_tag;
      d0 = rsp_data;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        // R8
        chk(rsp_valid && rsp_data == d0 && rsp_tag == otag, "R8 response held", rsp_data, d0);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
    end else if (done_pulse) begin
      got_done = 1'b1; otag = done_tag;
      @(negedge clk);
      // R9
      chk(!done_pulse, "R9 pulse one cycle", {63'd0, done_pulse}, 64'd0);
    end
  endtask

  task automatic peek(input logic [AW-1:0] ad, input string req, input logic [W-1:0] exp);
    logic [W-1:0] d; bit e, gr, gd; logic [TW-1:0] ot, it;
    run_op(4'd1, 1'b0, 1'b0, ad, '0, '0, 0, d, e, gr, gd, ot, it);
    chk(gr && !e && d == exp, req, d, exp);
  endtask

  task automatic chk_cnt(input string req);
    chk(cas_attempts == CW'(exp_att) && cas_failures == CW'(exp_fail), req,
        {cas_attempts, cas_failures}, {CW'(exp_att), CW'(exp_fail)});
  endtask

  initial begin
    logic [W-1:0] d, e_new; bit e, gr, gd, fc; logic [TW-1:0] ot, it;
    string rq;
    for (int i = 0; i < D; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(req_ready && !rsp_valid && !done_pulse, "R1 idle after reset",
        {61'd0, req_ready, rsp_valid, done_pulse}, 64'd4);
    chk_cnt("R1 counters zero");
    for (int i = 0; i < D; i++) peek(AW'(i), "R1 storage zero", '0);

    for (int sg = 0; sg < 2; sg++) begin
      for (int op = 0; op < 11; op++) begin
        for (int i = 0; i < 6; i++) begin
          for (int j = 0; j < 6; j++) begin
            logic [AW-1:0] ad;
            logic [W-1:0] bop;
            bit nr;
            ad = AW'(op + i + j);
            nr = ((i + j) % 2) == 1;
            bop = vals[(j + 1) % 6];
            run_op(4'd4, 1'b0, 1'b0, ad, vals[i], '0, 0, d, e, gr, gd, ot, it);
            // R4
            chk(gr && d == shadow[ad], "R4 exchange returns prior word", d, shadow[ad]);
            shadow[ad] = vals[i];
            e_new = ref_next(op, bit'(sg), vals[i], vals[j], bop, fc);
            run_op(4'(op), nr, bit'(sg), ad, vals[j], bop, 0, d, e, gr, gd, ot, it);
            if (nr) begin
              // R9
              chk(gd && !gr && ot == it, "R9 completion pulse with tag", {ot, gd, gr}, {it, 2'b10});
            end else begin
              // R8
              chk(gr && !e && d == vals[i] && ot == it, "R8 old value and tag", d, vals[i]);
            end
            shadow[ad] = e_new;
            if (op == 3) begin exp_att++; if (fc) exp_fail++; end
            case (op)
              0, 1, 2: rq = "R2 bitwise result";
              3:       rq = "R6 compare-and-swap result";
              4:       rq = "R4 exchange result";
              5, 6, 7, 8: rq = "R3 wrapping arithmetic";
              default: rq = "R5 max/min result";
            endcase
            peek(ad, rq, e_new);
            chk_cnt("R7 statistics counters");
          end
        end
      end
    end

    // R10 undefined codes in both forms
    for (int op = 11; op < 16; op++) begin
      for (int nr = 0; nr < 2; nr++) begin
        logic [AW-1:0] ad;
        ad = AW'(op);
        run_op(4'(op), bit'(nr), 1'b0, ad, 32'h1234_5678, 32'h9abc_def0, 0, d, e, gr, gd, ot, it);
        chk(gr && !gd && e && d == '0 && ot == it, "R10 error response", {d, 7'd0, e, ot}, {32'd0, 8'd1, it});
        peek(ad, "R10 storage unchanged", shadow[ad]);
        chk_cnt("R10 counters unchanged");
      end
    end

    // R8 back-pressure hold
    run_op(4'd7, 1'b0, 1'b0, 4'd2, '0, '0, 4, d, e, gr, gd, ot, it);
    chk(gr && d == shadow[2], "R8 held beat value", d, shadow[2]);
    shadow[2] = shadow[2] + 32'd1;
    peek(4'd2, "R3 increment after hold", shadow[2]);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

endmodule